// File: doc/BRIEF.md
# Serial Identity CRC-8 Checker

This block checks a 64-bit identity word that arrives one bit at a time, least significant bit first and byte by byte. The first 56 bits are a one-byte type code followed by a 48-bit serial number. They pass through a bit-serial CRC-8 engine built on the reflected generator x^8 + x^5 + x^4 + 1. The final 8 bits carry the CRC that the sender attached. The block collects those 8 bits and compares them with the value it has computed.

A host pulses `start` before each word and then presents every bit on `bit_in` with `bit_valid` high. Gaps between bits are allowed. The running CRC is visible on `crc_out` at all times. One cycle after the 64th accepted bit, `done` pulses for one cycle. `crc_ok` rises in that same cycle if the word is intact, and it holds its value until the next `start`.

Top module: `id_crc8_check`

## Requirements
- R1: While `rst_n` is low, `crc_out` is 0, `done` is 0 and `crc_ok` is 0.
- R2: A cycle with `start` high clears the CRC, the bit count, `done` and `crc_ok`. In the following cycle, `crc_out` is 0 and both flags are 0.
- R3: For each of the first 56 accepted bits, the engine forms f = `bit_in` XOR crc[0]. If f is 1, the register is XORed with 8'h18. The register is then shifted right by one place, and f enters bit 7. `crc_out` shows the result one cycle after the bit is accepted.
- R4: A cycle with `bit_valid` low and `start` low leaves `crc_out`, the bit count and `crc_ok` unchanged.
- R5: Accepted bits 57 to 64 are not fed to the CRC register. Once 56 bits have been accepted, `crc_out` stays constant until the next `start`.
- R6: `done` is high for exactly one cycle, the cycle after the 64th accepted bit.
- R7: `crc_ok` rises together with `done` when the computed CRC equals the trailing byte. Bit 57 of the word is the LSB of that byte and bit 64 is its MSB. Otherwise `crc_ok` stays 0. Its value holds until `start`.
- R8: Valid bits offered after the 64th accepted bit are ignored. They produce no new `done` pulse, no change of `crc_ok` and no change of `crc_out`.
- R9: When `start` and `bit_valid` are high in the same cycle, the bit is discarded and the clear takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Clears the engine before a new word |
| bit_valid | input | 1 | Qualifies `bit_in` |
| bit_in | input | 1 | Serial data bit, LSB first |
| crc_out | output | 8 | Running CRC register |
| done | output | 1 | One-cycle pulse after the 64th bit |
| crc_ok | output | 1 | Trailing byte matched the computed CRC |

## Verification
The hardest situations to reach are at the word's edges. One is the hand-over at bit 57, where the register must freeze while the trailing byte is still being collected. Another is the tail after the 64th bit, where extra valid bits must not retrigger the result. The stimulus reaches both by streaming whole words: valid identities, words with a corrupted data bit or CRC byte, and words with extra bits appended. It also inserts idle gaps, restarts a word partway through, and raises `start` in the same cycle as a valid bit. A behavioural model built on queues is compared with all three outputs on every clock.

// File: rtl/id_crc8_check.sv
module id_crc8_check #(
  parameter int DATA_BITS = 56,
  parameter int CHK_BITS  = 8,
  parameter logic [CHK_BITS-1:0] POLY_TAP = 8'h18
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                bit_valid,
  input  logic                bit_in,
  output logic [CHK_BITS-1:0] crc_out,
  output logic                done,
  output logic                crc_ok
);
  localparam int TOTAL = DATA_BITS + CHK_BITS;
  localparam int CW    = $clog2(TOTAL + 1);

  logic [CW-1:0]       bit_cnt;
  logic [CHK_BITS-1:0] crc_q, exp_q;

  wire                take    = bit_valid && !start && (bit_cnt != CW'(TOTAL));
  wire                in_data = bit_cnt < CW'(DATA_BITS);
  wire                last    = take && (bit_cnt == CW'(TOTAL - 1));
  wire                fb      = bit_in ^ crc_q[0];
  wire [CHK_BITS-1:0] mixed   = crc_q ^ ({CHK_BITS{fb}} & POLY_TAP);
  wire [CHK_BITS-1:0] crc_nx  = {fb, mixed[CHK_BITS-1:1]};
  wire [CHK_BITS-1:0] exp_nx  = {bit_in, exp_q[CHK_BITS-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      crc_q   <= '0;
      exp_q   <= '0;
      done    <= 1'b0;
      crc_ok  <= 1'b0;
    end else if (start) begin
      bit_cnt <= '0;
      crc_q   <= '0;
      exp_q   <= '0;
      done    <= 1'b0;
      crc_ok  <= 1'b0;
    end else begin
      done <= last;
      if (take) begin
        bit_cnt <= bit_cnt + CW'(1);
        if (in_data) crc_q <= crc_nx;
        else         exp_q <= exp_nx;
      end
      if (last) crc_ok <= (exp_nx == crc_q);
    end
  end

  assign crc_out = crc_q;
endmodule

module id_crc8_check_sva #(
  parameter int CW = 7,
  parameter int TOTAL = 64,
  parameter int CHK_BITS = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic                bit_valid,
  input logic [CW-1:0]       bit_cnt,
  input logic [CHK_BITS-1:0] crc_out,
  input logic                done,
  input logic                crc_ok
);
  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (crc_out == '0 && !done && !crc_ok));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !bit_valid) |=> ($stable(crc_out) && $stable(crc_ok)));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_ok_rises_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crc_ok) |-> done);

  assert_ok_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_ok && !start) |=> crc_ok);

  assert_tail_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_cnt == CW'(TOTAL) && !done && !start) |=> ($stable(crc_ok) && $stable(crc_out) && !done));
endmodule

bind id_crc8_check id_crc8_check_sva #(.CW(CW), .TOTAL(TOTAL), .CHK_BITS(CHK_BITS)) u_sva (
  .clk(clk), .rst_n(rst_n), .start(start), .bit_valid(bit_valid),
  .bit_cnt(bit_cnt), .crc_out(crc_out), .done(done), .crc_ok(crc_ok)
);

// File: tb/id_crc8_check_tb.sv
module id_crc8_check_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       bit_valid = 1'b0;
  logic       bit_in = 1'b0;
  logic [7:0] crc_out;
  logic       done, crc_ok;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  id_crc8_check u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .bit_valid(bit_valid),
    .bit_in(bit_in), .crc_out(crc_out), .done(done), .crc_ok(crc_ok)
  );

  always #2 clk = ~clk;

  bit m_bits[$];
  int m_done = 0;
  int m_ok = 0;

  function automatic int model_crc();
    int c = 0;
    for (int i = 0; i < m_bits.size() && i < 56; i++) begin
      if (((c ^ int'(m_bits[i])) & 1) != 0) c = (c >> 1) ^ 8'h8C;
      else c = c >> 1;
    end
    return c;
  endfunction

  function automatic logic [7:0] crc_of(input logic [55:0] d);
    int c = 0;
    for (int i = 0; i < 56; i++) begin
      if (((c ^ int'(d[i])) & 1) != 0) c = (c >> 1) ^ 8'h8C;
      else c = c >> 1;
    end
    return 8'(c);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic s, input logic v, input logic b);
    @(negedge clk);
    start = s; bit_valid = v; bit_in = b;
    @(posedge clk);
    #1;
    m_done = 0;
    if (s) begin
      m_bits.delete();
      m_ok = 0;
    end else if (v && m_bits.size() < 64) begin
      m_bits.push_back(b);
      if (m_bits.size() == 64) begin
        int e = 0;
        for (int i = 0; i < 8; i++) e |= int'(m_bits[56 + i]) << i;
        m_done = 1;
        m_ok = (e == model_crc()) ? 1 : 0;
      end
    end
    chk("R3 crc_out per clock", int'(crc_out), model_crc());
    chk("R6 done per clock", int'(done), m_done);
    chk("R7 crc_ok per clock", int'(crc_ok), m_ok);
  endtask

  task automatic send_word(input logic [63:0] w, input int gap_every);
    for (int i = 0; i < 64; i++) begin
      step(1'b0, 1'b1, w[i]);
      if (gap_every > 0 && (i % gap_every) == 0) step(1'b0, 1'b0, ~w[i]);
    end
  endtask

  initial begin
    logic [55:0] d;
    logic [63:0] good;
    logic [7:0]  snap;

    d    = {48'h000000FBC52B, 8'h01};
    good = {crc_of(d), d};

    #1;
    chk("R1 crc_out in reset", int'(crc_out), 0);
    chk("R1 done in reset", int'(done), 0);
    chk("R1 crc_ok in reset", int'(crc_ok), 0);
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    step(1'b1, 1'b0, 1'b0);
    send_word(good, 3);
    chk("R7 good word passes", int'(crc_ok), 1);
    chk("R5 crc frozen after 56 bits", int'(crc_out), int'(crc_of(d)));

    snap = crc_out;
    step(1'b0, 1'b0, 1'b1);
    chk("R4 idle cycle holds crc", int'(crc_out), int'(snap));

    for (int i = 0; i < 6; i++) step(1'b0, 1'b1, 1'(i));
    chk("R8 extra bits keep ok", int'(crc_ok), 1);
    chk("R8 extra bits keep crc", int'(crc_out), int'(snap));

    step(1'b1, 1'b0, 1'b0);
    chk("R2 start clears crc", int'(crc_out), 0);
    chk("R2 start clears ok", int'(crc_ok), 0);

    send_word(good ^ (64'd1 << 60), 0);
    chk("R7 corrupted check byte fails", int'(crc_ok), 0);

    step(1'b1, 1'b0, 1'b0);
    send_word(good ^ (64'd1 << 17), 5);
    chk("R7 corrupted data bit fails", int'(crc_ok), 0);

    step(1'b1, 1'b0, 1'b0);
    send_word(64'd0, 0);
    chk("R7 all-zero word passes", int'(crc_ok), 1);

    step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b1);
    chk("R9 bit with start discarded", int'(crc_out), 0);
    step(1'b0, 1'b0, 1'b0);
    chk("R9 crc still clear", int'(crc_out), 0);

    for (int i = 0; i < 20; i++) step(1'b0, 1'b1, 1'b1);
    step(1'b1, 1'b0, 1'b0);
    chk("R2 restart mid-word clears", int'(crc_out), 0);
    d    = {48'h5A5A_0123_89AB, 8'h28};
    good = {crc_of(d), d};
    send_word(good, 7);
    chk("R7 restarted word passes", int'(crc_ok), 1);
    step(1'b0, 1'b0, 1'b0);
    chk("R6 done low after pulse", int'(done), 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule